// File: doc/BRIEF.md
# Register Rename Unit

This block renames architectural registers onto a larger pool of physical registers. A translation table, indexed by architectural register number, holds the physical tag that currently carries each architectural value. A queue of unused physical tags supplies a new tag whenever an instruction writes a register. A table of per-tag ready bits tells a consumer whether a value already exists or must still be waited for. Because every write gets its own physical home, write-after-read and write-after-write conflicts vanish, and renaming never waits on them.

One instruction is offered per cycle, with two source registers and an optional destination. In the same cycle the block returns the physical tags and ready flags of both sources, the new destination tag, and the tag the destination used to map to. Commit later hands that old tag back through the release port once no in-flight instruction can still read it. Execution units report finished results on the broadcast lanes, and the matching ready bits are set.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical tag i and reads as ready; tags from the architectural count up to the physical count minus one are free and not ready.
- R2: Free tags are handed out in first-in first-out order: after reset in increasing order starting at the architectural count, and a released tag joins the back of the queue.
- R3: A rename that fires with a destination makes the next lookup of that register return the newly handed-out tag, which reads as not ready until broadcast.
- R4: `ren_pdst_old` carries the tag the destination mapped to before the rename.
- R5: Sources are looked up before the destination is updated, so an instruction that reads and writes the same register gets the old tag for its source.
- R6: `ren_ready` is low only when `ren_has_dst` is high and no free tag remains; a rename offered while it is low changes no mapping and consumes no tag.
- R7: A broadcast on any lane makes a source with that tag read as ready in the same cycle, and the ready bit stays set from the next cycle on.
- R8: A released tag becomes available for allocation after all tags already queued.
- R9: Back-to-back writes to the same register never stall while free tags remain and each receives a distinct tag.
- R10: With `ren_valid` low no mapping changes and no tag is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | An instruction is offered for renaming |
| ren_src1 | input | ATAG_W | First source architectural register |
| ren_src2 | input | ATAG_W | Second source architectural register |
| ren_has_dst | input | 1 | Instruction writes a destination |
| ren_dst | input | ATAG_W | Destination architectural register |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_psrc1 | output | PTAG_W | Physical tag of source 1 |
| ren_psrc1_rdy | output | 1 | Source 1 value is available |
| ren_psrc2 | output | PTAG_W | Physical tag of source 2 |
| ren_psrc2_rdy | output | 1 | Source 2 value is available |
| ren_pdst | output | PTAG_W | Newly assigned destination tag |
| ren_pdst_old | output | PTAG_W | Prior mapping of the destination |
| wb_valid | input | NUM_WB | Per-lane result broadcast strobe |
| wb_tag | input | NUM_WB*PTAG_W | Per-lane broadcast tags, lane 0 in the low bits |
| rel_valid | input | 1 | Commit returns a tag to the free queue |
| rel_tag | input | PTAG_W | Tag being returned |

## Verification
Lookups straight after reset separate an identity mapping from any other initial table. Renames whose destination equals a source, and two renames of the same register in a row, tell apart look-up-before-update from update-first and show that distinct tags are issued without stalling. Broadcasts on the second lane in the same cycle as a lookup distinguish the same-cycle bypass from a registered-only ready bit. Draining the queue to empty, then releasing two tags out of numeric order, shows the stall condition, that a stalled or invalid offer leaves the table alone, and that reuse follows release order.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int ARCH_REGS_DEF = 16;
  localparam int PHYS_REGS_DEF = 32;
  localparam int WB_LANES_DEF  = 2;

  // Circular index advance for a structure of the given depth.
  function automatic int wrap_inc(input int cur, input int depth);
    return (cur == depth - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = rn_pkg::ARCH_REGS_DEF,
  parameter int NUM_PHYS = rn_pkg::PHYS_REGS_DEF,
  localparam int ATAG_W = $clog2(NUM_ARCH),
  localparam int PTAG_W = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ATAG_W-1:0] rd_idx_a,
  input  logic [ATAG_W-1:0] rd_idx_b,
  input  logic [ATAG_W-1:0] rd_idx_c,
  output logic [PTAG_W-1:0] rd_tag_a,
  output logic [PTAG_W-1:0] rd_tag_b,
  output logic [PTAG_W-1:0] rd_tag_c,
  input  logic              wr_en,
  input  logic [ATAG_W-1:0] wr_idx,
  input  logic [PTAG_W-1:0] wr_tag
);
  logic [PTAG_W-1:0] map_q [NUM_ARCH];
  logic [PTAG_W-1:0] map_d [NUM_ARCH];

  // Reads see the registered table, i.e. the state before this cycle's write.
  assign rd_tag_a = map_q[rd_idx_a];
  assign rd_tag_b = map_q[rd_idx_b];
  assign rd_tag_c = map_q[rd_idx_c];

  always_comb begin
    map_d = map_q;
    if (wr_en) map_d[wr_idx] = wr_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PTAG_W'(i);
    end else if (wr_en) begin
      map_q <= map_d;
    end
  end

  // R3: a written entry holds the tag it was given
  a_r3_map_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> map_q[$past(wr_idx)] == $past(wr_tag));
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int NUM_ARCH = rn_pkg::ARCH_REGS_DEF,
  parameter int NUM_PHYS = rn_pkg::PHYS_REGS_DEF,
  localparam int PTAG_W   = $clog2(NUM_PHYS),
  localparam int CNT_W    = $clog2(NUM_PHYS + 1),
  localparam int NUM_INIT = NUM_PHYS - NUM_ARCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic              push,
  input  logic [PTAG_W-1:0] push_tag,
  output logic [PTAG_W-1:0] head_tag,
  output logic              empty
);
  logic [PTAG_W-1:0] slot_q [NUM_PHYS];
  logic [PTAG_W-1:0] slot_d [NUM_PHYS];
  logic [PTAG_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              upd_en;

  assign head_tag = slot_q[rd_q];
  assign empty    = (cnt_q == '0);
  assign upd_en   = pop | push;

  always_comb begin
    slot_d = slot_q;
    rd_d   = rd_q;
    wr_d   = wr_q;
    if (pop) rd_d = PTAG_W'(rn_pkg::wrap_inc(int'(rd_q), NUM_PHYS));
    if (push) begin
      slot_d[wr_q] = push_tag;
      wr_d = PTAG_W'(rn_pkg::wrap_inc(int'(wr_q), NUM_PHYS));
    end
    cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++)
        slot_q[i] <= (i < NUM_INIT) ? PTAG_W'(NUM_ARCH + i) : '0;
      rd_q  <= '0;
      wr_q  <= PTAG_W'(NUM_INIT % NUM_PHYS);
      cnt_q <= CNT_W'(NUM_INIT);
    end else if (upd_en) begin
      slot_q <= slot_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      cnt_q  <= cnt_d;
    end
  end

  // R6: nothing is taken from an empty queue
  a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt_q != '0);
  // R8: a release never overfills the queue
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> cnt_q < CNT_W'(NUM_PHYS));
  // R2: the head moves on exactly when a tag is taken
  a_r2_head_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> rd_q == $past(rd_q));
endmodule

// File: rtl/rn_ready_table.sv
module rn_ready_table #(
  parameter int NUM_ARCH = rn_pkg::ARCH_REGS_DEF,
  parameter int NUM_PHYS = rn_pkg::PHYS_REGS_DEF,
  parameter int NUM_WB   = rn_pkg::WB_LANES_DEF,
  localparam int PTAG_W = $clog2(NUM_PHYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_WB-1:0]        wb_valid,
  input  logic [NUM_WB*PTAG_W-1:0] wb_tag,
  input  logic                     clr_en,
  input  logic [PTAG_W-1:0]        clr_tag,
  input  logic [PTAG_W-1:0]        look_tag_a,
  input  logic [PTAG_W-1:0]        look_tag_b,
  output logic                     look_rdy_a,
  output logic                     look_rdy_b
);
  logic [NUM_PHYS-1:0] rdy_q, rdy_d;
  logic [NUM_WB-1:0]   hit_a, hit_b;
  logic                upd_en;

  // Same-cycle bypass: a tag being broadcast now already counts as ready.
  for (genvar l = 0; l < NUM_WB; l++) begin : g_lane
    assign hit_a[l] = wb_valid[l] && (wb_tag[l*PTAG_W +: PTAG_W] == look_tag_a);
    assign hit_b[l] = wb_valid[l] && (wb_tag[l*PTAG_W +: PTAG_W] == look_tag_b);
  end

  assign look_rdy_a = rdy_q[look_tag_a] | (|hit_a);
  assign look_rdy_b = rdy_q[look_tag_b] | (|hit_b);
  assign upd_en     = clr_en | (|wb_valid);

  always_comb begin
    rdy_d = rdy_q;
    for (int l = 0; l < NUM_WB; l++)
      if (wb_valid[l]) rdy_d[wb_tag[l*PTAG_W +: PTAG_W]] = 1'b1;
    if (clr_en) rdy_d[clr_tag] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) rdy_q[i] <= (i < NUM_ARCH);
    end else if (upd_en) begin
      rdy_q <= rdy_d;
    end
  end

  // R3: a freshly assigned tag starts out not ready
  a_r3_alloc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !rdy_q[$past(clr_tag)]);
  // R7: a broadcast on lane 0 leaves its tag ready
  a_r7_wb_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid[0] && !(clr_en && clr_tag == wb_tag[PTAG_W-1:0]))
      |=> rdy_q[$past(wb_tag[PTAG_W-1:0])]);
endmodule

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NUM_ARCH = rn_pkg::ARCH_REGS_DEF,
  parameter int NUM_PHYS = rn_pkg::PHYS_REGS_DEF,
  parameter int NUM_WB   = rn_pkg::WB_LANES_DEF,
  localparam int ATAG_W = $clog2(NUM_ARCH),
  localparam int PTAG_W = $clog2(NUM_PHYS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ren_valid,
  input  logic [ATAG_W-1:0]        ren_src1,
  input  logic [ATAG_W-1:0]        ren_src2,
  input  logic                     ren_has_dst,
  input  logic [ATAG_W-1:0]        ren_dst,
  output logic                     ren_ready,
  output logic [PTAG_W-1:0]        ren_psrc1,
  output logic                     ren_psrc1_rdy,
  output logic [PTAG_W-1:0]        ren_psrc2,
  output logic                     ren_psrc2_rdy,
  output logic [PTAG_W-1:0]        ren_pdst,
  output logic [PTAG_W-1:0]        ren_pdst_old,
  input  logic [NUM_WB-1:0]        wb_valid,
  input  logic [NUM_WB*PTAG_W-1:0] wb_tag,
  input  logic                     rel_valid,
  input  logic [PTAG_W-1:0]        rel_tag
);
  logic fl_empty;
  logic alloc;

  assign ren_ready = !(ren_has_dst && fl_empty);
  assign alloc     = ren_valid && ren_ready && ren_has_dst;

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx_a (ren_src1),
    .rd_idx_b (ren_src2),
    .rd_idx_c (ren_dst),
    .rd_tag_a (ren_psrc1),
    .rd_tag_b (ren_psrc2),
    .rd_tag_c (ren_pdst_old),
    .wr_en    (alloc),
    .wr_idx   (ren_dst),
    .wr_tag   (ren_pdst)
  );

  rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (alloc),
    .push     (rel_valid),
    .push_tag (rel_tag),
    .head_tag (ren_pdst),
    .empty    (fl_empty)
  );

  rn_ready_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_WB(NUM_WB)) u_rdy (
    .clk        (clk),
    .rst_n      (rst_n),
    .wb_valid   (wb_valid),
    .wb_tag     (wb_tag),
    .clr_en     (alloc),
    .clr_tag    (ren_pdst),
    .look_tag_a (ren_psrc1),
    .look_tag_b (ren_psrc2),
    .look_rdy_a (ren_psrc1_rdy),
    .look_rdy_b (ren_psrc2_rdy)
  );

  // R5: a source naming the destination sees the pre-rename mapping
  a_r5_src_sees_old: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && ren_src1 == ren_dst) |-> ren_psrc1 == ren_pdst_old);
  // R9: the new tag never equals the mapping it replaces
  a_r9_fresh_tag: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> ren_pdst != ren_pdst_old);
endmodule

// File: tb/tb_reg_rename.sv
`timescale 1ns/100ps
module tb_reg_rename;
  localparam int NA = 16;
  localparam int NP = 32;
  localparam int NW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, ren_has_dst = 1'b0;
  logic [3:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
  logic ren_ready, ren_psrc1_rdy, ren_psrc2_rdy;
  logic [4:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pdst_old;
  logic [NW-1:0] wb_valid = '0;
  logic [NW*5-1:0] wb_tag = '0;
  logic rel_valid = 1'b0;
  logic [4:0] rel_tag = '0;

  always #2.5 clk = ~clk;

  reg_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_WB(NW)) dut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_src1(ren_src1),
    .ren_src2(ren_src2), .ren_has_dst(ren_has_dst), .ren_dst(ren_dst),
    .ren_ready(ren_ready), .ren_psrc1(ren_psrc1), .ren_psrc1_rdy(ren_psrc1_rdy),
    .ren_psrc2(ren_psrc2), .ren_psrc2_rdy(ren_psrc2_rdy), .ren_pdst(ren_pdst),
    .ren_pdst_old(ren_pdst_old), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .rel_valid(rel_valid), .rel_tag(rel_tag));

  typedef struct {
    string req;
    bit v, hd, rdy, r1, r2;
    int p1, p2, pd, old;
  } item_t;

  item_t exp_q[$];
  int map_m[NA];
  bit rdy_m[NP];
  int fl_m[$];
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, queues expectations, updates the model.
  task automatic step(input string req, input bit v, input int s1, input int s2,
                      input bit hd, input int d, input bit [NW-1:0] wbv,
                      input int wt0, input int wt1, input bit rv, input int rt);
    item_t it;
    @(negedge clk);
    ren_valid = v; ren_src1 = 4'(s1); ren_src2 = 4'(s2);
    ren_has_dst = hd; ren_dst = 4'(d);
    wb_valid = wbv; wb_tag = {5'(wt1), 5'(wt0)};
    rel_valid = rv; rel_tag = 5'(rt);
    it.req = req; it.v = v; it.hd = hd;
    it.rdy = !hd || (fl_m.size() > 0);
    it.p1 = map_m[s1]; it.p2 = map_m[s2];
    it.r1 = rdy_m[it.p1] || (wbv[0] && wt0 == it.p1) || (wbv[1] && wt1 == it.p1);
    it.r2 = rdy_m[it.p2] || (wbv[0] && wt0 == it.p2) || (wbv[1] && wt1 == it.p2);
    it.pd = (fl_m.size() > 0) ? fl_m[0] : -1;
    it.old = map_m[d];
    exp_q.push_back(it);
    @(posedge clk);
    #1;
    if (wbv[0]) rdy_m[wt0] = 1'b1;
    if (wbv[1]) rdy_m[wt1] = 1'b1;
    if (v && it.rdy && hd) begin
      int nt;
      nt = fl_m.pop_front();
      map_m[d] = nt;
      rdy_m[nt] = 1'b0;
    end
    if (rv) fl_m.push_back(rt);
  endtask

  // Monitor: compares combinational results shortly after inputs settle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.req, "ren_ready", int'(ren_ready), int'(it.rdy));
        if (it.v) begin
          chk(it.req, "psrc1", int'(ren_psrc1), it.p1);
          chk(it.req, "psrc1_rdy", int'(ren_psrc1_rdy), int'(it.r1));
          chk(it.req, "psrc2", int'(ren_psrc2), it.p2);
          chk(it.req, "psrc2_rdy", int'(ren_psrc2_rdy), int'(it.r2));
          if (it.hd && it.rdy) begin
            chk(it.req, "pdst", int'(ren_pdst), it.pd);
            chk(it.req, "pdst_old", int'(ren_pdst_old), it.old);
          end
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) rdy_m[i] = (i < NA);
    for (int i = NA; i < NP; i++) fl_m.push_back(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: identity map and ready after reset
    step("R1", 1, 0, 15, 0, 0, 2'b00, 0, 0, 0, 0);
    step("R1", 1, 3, 7, 0, 0, 2'b00, 0, 0, 0, 0);
    // R5 / R4: source equals destination, old tag reported
    step("R5", 1, 5, 5, 1, 5, 2'b00, 0, 0, 0, 0);
    // R3: new tag visible and not ready
    step("R3", 1, 5, 2, 0, 0, 2'b00, 0, 0, 0, 0);
    // R9: second write to the same register, no stall, distinct tag
    step("R9", 1, 5, 5, 1, 5, 2'b00, 0, 0, 0, 0);
    // R7: same-cycle bypass on lane 1, then registered ready
    step("R7", 1, 5, 2, 0, 0, 2'b11, 16, 17, 0, 0);
    step("R7", 1, 5, 5, 0, 0, 2'b00, 0, 0, 0, 0);
    // R10: invalid offer changes nothing
    step("R10", 0, 9, 9, 1, 9, 2'b00, 0, 0, 0, 0);
    step("R10", 1, 9, 5, 0, 0, 2'b00, 0, 0, 0, 0);
    // R2: drain remaining free tags in order
    for (int k = 0; k < 14; k++) step("R2", 1, k, 15, 1, k, 2'b00, 0, 0, 0, 0);
    // R6: stall when empty with destination, no stall without
    step("R6", 1, 15, 15, 1, 15, 2'b00, 0, 0, 0, 0);
    step("R6", 1, 15, 0, 0, 0, 2'b00, 0, 0, 0, 0);
    // R8: release two tags out of numeric order
    step("R8", 1, 15, 14, 0, 0, 2'b00, 0, 0, 1, 16);
    step("R8", 1, 15, 14, 0, 0, 2'b00, 0, 0, 1, 5);
    step("R8", 1, 15, 14, 1, 15, 2'b00, 0, 0, 0, 0);
    step("R8", 1, 14, 15, 1, 14, 2'b00, 0, 0, 0, 0);
    // R2 / R6: empty again
    step("R2", 1, 15, 14, 1, 3, 2'b00, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 2'b00, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule